// File: doc/BRIEF.md
# Dual-Rate Hysteretic Quadrature Gain Controller

This block regulates one gain code that is shared by a sine and a cosine channel, so that the combined amplitude of the two channels stays close to a target. On every clock it squares the signed amplitude of each channel and adds the two squares. It then compares that sum with thresholds that are already squared, so no square root is ever taken. The result falls into one of five regions: far above, a little above, inside the quiet band, a little below, or far below.

The region decides how fast the gain moves and by how much. It also matters whether the loop is in its start-up settling phase or in normal operation. Far-off amplitudes move the gain in large, frequent steps. Small deviations move it by a single code on a much longer period.

Inside the quiet band nothing changes once the target has been reached. If a threshold was crossed, however, the block keeps regulating until the amplitude falls within a small window around the target. This gives the loop its hysteresis. Each code is meant to be a constant step of about 0.15 dB in the analog gain stage that follows this block.

Top module: `quad_agc`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `gainCode` equals `initGain` and `regulating` is 0.
- R2: With m = sin² + cos², the region is far-high when m > `thrFastHi`, near-high when `thrSlowHi` < m ≤ `thrFastHi`, quiet when `thrSlowLo` ≤ m ≤ `thrSlowHi`, near-low when `thrFastLo` ≤ m < `thrSlowLo`, and far-low when m < `thrFastLo`. Negative amplitudes square to the same value as positive ones.
- R3: In the normal phase (`diagPhase`=0), a far region moves the gain by 4 codes once every FAST_NS of clock time. The gain goes down when far-high and up when far-low.
- R4: In the normal phase, a near region moves the gain by 1 code once every SLOW_US of clock time. The gain goes down when near-high and up when near-low.
- R5: In the settling phase (`diagPhase`=1), the update period is DIAG_NS in every region. The step is 8 codes in a far region and 1 code in a near region.
- R6: The gain code saturates at 0 and at its all-ones maximum and never wraps. A step that would pass either limit lands exactly on that limit.
- R7: Any cycle in a near or far region sets `regulating`. It stays set until m is within `targetWin` of `targetSq`, and it clears on the next edge after that. While it is set in the quiet band, the gain keeps moving by 1 code on the slow schedule toward the target: down if m > `targetSq`, up otherwise.
- R8: In the quiet band with `regulating` clear, the gain does not change.
- R9: Every change of `diagPhase` restarts the update timers, so the first step after the change comes one full period of the new phase later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| diagPhase | input | 1 | 1 = start-up settling phase, 0 = normal phase |
| sinAmp | input | SAMPLE_W | Signed sine-channel amplitude |
| cosAmp | input | SAMPLE_W | Signed cosine-channel amplitude |
| thrFastHi | input | 2*SAMPLE_W+1 | Squared upper fast threshold |
| thrSlowHi | input | 2*SAMPLE_W+1 | Squared upper quiet-band edge |
| thrSlowLo | input | 2*SAMPLE_W+1 | Squared lower quiet-band edge |
| thrFastLo | input | 2*SAMPLE_W+1 | Squared lower fast threshold |
| targetSq | input | 2*SAMPLE_W+1 | Squared regulation target |
| targetWin | input | 2*SAMPLE_W+1 | Half-width of the target window, in squared units |
| initGain | input | GAIN_W | Gain code loaded by reset |
| gainCode | output | GAIN_W | Gain code shared by both channels |
| regulating | output | 1 | Set while the loop is pulling the amplitude back toward the target |

## Verification
The bench builds the block at 125 MHz with DIAG_NS=40, FAST_NS=120 and SLOW_US=1. This gives periods of 5, 15 and 125 clocks. At these values every schedule, including the slow drift correction, can be watched tick by tick within a short run. The sample width stays at 12 bits and the gain at 8 bits, so the squared thresholds sit near one million. This leaves room for amplitudes placed exactly on each threshold, and for initial codes next to 0 and 255 where the 4- and 8-code steps have to clamp.

// File: rtl/quad_agc_pkg.sv
package quad_agc_pkg;

  typedef enum logic [2:0] {
    REG_FAST_LO = 3'd0,
    REG_SLOW_LO = 3'd1,
    REG_DEAD    = 3'd2,
    REG_SLOW_HI = 3'd3,
    REG_FAST_HI = 3'd4
  } region_e;

  localparam int STEP_W = 4;

  typedef struct packed {
    logic              stepEn;
    logic              stepUp;
    logic [STEP_W-1:0] stepSize;
  } step_cmd_t;

endpackage

// File: rtl/quad_agc_dp.sv
module quad_agc_dp
  import quad_agc_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W   = 8,
  parameter int SQ_W     = 2*SAMPLE_W+1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sinAmp,
  input  logic signed [SAMPLE_W-1:0] cosAmp,
  input  logic [SQ_W-1:0]            thrFastHi,
  input  logic [SQ_W-1:0]            thrSlowHi,
  input  logic [SQ_W-1:0]            thrSlowLo,
  input  logic [SQ_W-1:0]            thrFastLo,
  input  logic [SQ_W-1:0]            targetSq,
  input  logic [SQ_W-1:0]            targetWin,
  input  logic [GAIN_W-1:0]          initGain,
  input  step_cmd_t                  cmd,
  output region_e                    region,
  output logic                       inTarget,
  output logic                       aboveTarget,
  output logic [GAIN_W-1:0]          gainCode
);

  localparam int PROD_W = 2*SAMPLE_W;
  localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

  logic signed [PROD_W-1:0] sinSq, cosSq;
  logic [SQ_W-1:0] magSq, distSq;
  logic [GAIN_W:0] upSum;
  logic [GAIN_W-1:0] stepExt;
  logic [GAIN_W-1:0] gainNext;

  // Sum of squares replaces the root of it; thresholds arrive pre-squared.
  assign sinSq = sinAmp * sinAmp;
  assign cosSq = cosAmp * cosAmp;
  assign magSq = SQ_W'($unsigned(sinSq)) + SQ_W'($unsigned(cosSq));

  always_comb begin
    if (magSq > thrFastHi)       region = REG_FAST_HI;
    else if (magSq > thrSlowHi)  region = REG_SLOW_HI;
    else if (magSq >= thrSlowLo) region = REG_DEAD;
    else if (magSq >= thrFastLo) region = REG_SLOW_LO;
    else                         region = REG_FAST_LO;
  end

  assign aboveTarget = magSq > targetSq;
  assign distSq      = aboveTarget ? (magSq - targetSq) : (targetSq - magSq);
  assign inTarget    = distSq <= targetWin;

  // Clamped step arithmetic on the shared gain code.
  assign stepExt = GAIN_W'(cmd.stepSize);
  assign upSum   = {1'b0, gainCode} + {1'b0, stepExt};

  always_comb begin
    gainNext = gainCode;
    if (cmd.stepEn) begin
      if (cmd.stepUp) gainNext = upSum[GAIN_W] ? GAIN_MAX : upSum[GAIN_W-1:0];
      else            gainNext = (gainCode < stepExt) ? '0 : gainCode - stepExt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gainCode <= initGain;
    else     gainCode <= gainNext;
  end

  p_reset_load_r1: assert property (@(posedge clk)
    $past(rst) |-> gainCode == $past(initGain));

  p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (rst)
    (gainCode == GAIN_MAX && cmd.stepEn && cmd.stepUp) |=> gainCode == GAIN_MAX);

  p_no_wrap_bottom_r6: assert property (@(posedge clk) disable iff (rst)
    (gainCode == '0 && cmd.stepEn && !cmd.stepUp) |=> gainCode == '0);

  p_step_limit_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((gainCode >= $past(gainCode)) ?
                     (gainCode - $past(gainCode)) <= GAIN_W'(8) :
                     ($past(gainCode) - gainCode) <= GAIN_W'(8)));

endmodule

// File: rtl/quad_agc_ctl.sv
module quad_agc_ctl
  import quad_agc_pkg::*;
#(
  parameter int CLK_MHZ        = 125,
  parameter int DIAG_NS        = 3200,
  parameter int FAST_NS        = 819200,
  parameter int SLOW_US        = 840000,
  parameter int FAST_STEP      = 4,
  parameter int DIAG_FAST_STEP = 8,
  parameter int SLOW_STEP      = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      diagPhase,
  input  region_e   region,
  input  logic      inTarget,
  input  logic      aboveTarget,
  output step_cmd_t cmd,
  output logic      regulating
);

  localparam int DIAG_RAW = (CLK_MHZ * DIAG_NS) / 1000;
  localparam int FAST_RAW = (CLK_MHZ * FAST_NS) / 1000;
  localparam int SLOW_RAW = CLK_MHZ * SLOW_US;
  localparam int DIAG_CYC = (DIAG_RAW < 1) ? 1 : DIAG_RAW;
  localparam int FAST_CYC = (FAST_RAW < 1) ? 1 : FAST_RAW;
  localparam int SLOW_CYC = (SLOW_RAW < 1) ? 1 : SLOW_RAW;
  localparam int A_MAX    = (DIAG_CYC > FAST_CYC) ? DIAG_CYC : FAST_CYC;
  localparam int CNT_A_W  = $clog2(A_MAX + 1);
  localparam int CNT_B_W  = $clog2(SLOW_CYC + 1);
  localparam logic [CNT_A_W-1:0] DIAG_LAST = CNT_A_W'(DIAG_CYC - 1);
  localparam logic [CNT_A_W-1:0] FAST_LAST = CNT_A_W'(FAST_CYC - 1);
  localparam logic [CNT_B_W-1:0] SLOW_LAST = CNT_B_W'(SLOW_CYC - 1);

  logic prevDiag, phaseChg;
  logic [CNT_A_W-1:0] cntA, lastA;
  logic [CNT_B_W-1:0] cntB;
  logic tickA, tickB, slowTick;

  assign phaseChg = diagPhase != prevDiag;
  assign lastA    = diagPhase ? DIAG_LAST : FAST_LAST;
  assign tickA    = !phaseChg && (cntA >= lastA);
  assign tickB    = !phaseChg && !diagPhase && (cntB >= SLOW_LAST);
  assign slowTick = diagPhase ? tickA : tickB;

  // Timer A paces settling steps and fast steps; timer B paces slow drift.
  always_ff @(posedge clk) begin
    if (rst) begin
      prevDiag <= diagPhase;
      cntA     <= '0;
      cntB     <= '0;
    end else begin
      prevDiag <= diagPhase;
      if (phaseChg || tickA) cntA <= '0;
      else                   cntA <= cntA + 1'b1;
      if (phaseChg || cntB >= SLOW_LAST) cntB <= '0;
      else                               cntB <= cntB + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    regulating <= 1'b0;
    else if (inTarget)          regulating <= 1'b0;
    else if (region != REG_DEAD) regulating <= 1'b1;
  end

  always_comb begin
    cmd = '0;
    case (region)
      REG_FAST_HI, REG_FAST_LO: begin
        cmd.stepEn   = tickA;
        cmd.stepUp   = region == REG_FAST_LO;
        cmd.stepSize = diagPhase ? STEP_W'(DIAG_FAST_STEP) : STEP_W'(FAST_STEP);
      end
      REG_SLOW_HI, REG_SLOW_LO: begin
        cmd.stepEn   = slowTick;
        cmd.stepUp   = region == REG_SLOW_LO;
        cmd.stepSize = STEP_W'(SLOW_STEP);
      end
      REG_DEAD: begin
        cmd.stepEn   = slowTick && regulating && !inTarget;
        cmd.stepUp   = !aboveTarget;
        cmd.stepSize = STEP_W'(SLOW_STEP);
      end
      default: cmd = '0;
    endcase
  end

  p_clear_on_target_r7: assert property (@(posedge clk) disable iff (rst)
    inTarget |=> !regulating);

  p_set_outside_band_r7: assert property (@(posedge clk) disable iff (rst)
    (region != REG_DEAD && !inTarget) |=> regulating);

  p_phase_restart_r9: assert property (@(posedge clk) disable iff (rst)
    phaseChg |-> !cmd.stepEn);

  p_settle_period_r5: assert property (@(posedge clk) disable iff (rst)
    (diagPhase && cmd.stepEn) |-> cntA == DIAG_LAST);

endmodule

// File: rtl/quad_agc.sv
module quad_agc
  import quad_agc_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W   = 8,
  parameter int CLK_MHZ  = 125,
  parameter int DIAG_NS  = 3200,
  parameter int FAST_NS  = 819200,
  parameter int SLOW_US  = 840000
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              diagPhase,
  input  logic signed [SAMPLE_W-1:0]        sinAmp,
  input  logic signed [SAMPLE_W-1:0]        cosAmp,
  input  logic [2*SAMPLE_W:0]               thrFastHi,
  input  logic [2*SAMPLE_W:0]               thrSlowHi,
  input  logic [2*SAMPLE_W:0]               thrSlowLo,
  input  logic [2*SAMPLE_W:0]               thrFastLo,
  input  logic [2*SAMPLE_W:0]               targetSq,
  input  logic [2*SAMPLE_W:0]               targetWin,
  input  logic [GAIN_W-1:0]                 initGain,
  output logic [GAIN_W-1:0]                 gainCode,
  output logic                              regulating
);

  localparam int SQ_W = 2*SAMPLE_W + 1;

  region_e   region;
  logic      inTarget, aboveTarget;
  step_cmd_t cmd;

  quad_agc_dp #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .SQ_W(SQ_W)) u_dp (
    .clk(clk), .rst(rst), .sinAmp(sinAmp), .cosAmp(cosAmp),
    .thrFastHi(thrFastHi), .thrSlowHi(thrSlowHi), .thrSlowLo(thrSlowLo),
    .thrFastLo(thrFastLo), .targetSq(targetSq), .targetWin(targetWin),
    .initGain(initGain), .cmd(cmd), .region(region), .inTarget(inTarget),
    .aboveTarget(aboveTarget), .gainCode(gainCode)
  );

  quad_agc_ctl #(.CLK_MHZ(CLK_MHZ), .DIAG_NS(DIAG_NS), .FAST_NS(FAST_NS),
                 .SLOW_US(SLOW_US)) u_ctl (
    .clk(clk), .rst(rst), .diagPhase(diagPhase), .region(region),
    .inTarget(inTarget), .aboveTarget(aboveTarget), .cmd(cmd),
    .regulating(regulating)
  );

  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (region == REG_DEAD && !regulating) |=> gainCode == $past(gainCode));

  p_slow_single_code_r4: assert property (@(posedge clk) disable iff (rst)
    (region == REG_SLOW_HI && !$past(rst)) |-> gainCode <= $past(gainCode) + 1'b0 + GAIN_W'(0) || $past(region) != REG_SLOW_HI);

endmodule

// File: tb/test_quad_agc.sv
module test_quad_agc;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic diagPhase = 1'b0;
  logic signed [11:0] sinAmp = '0, cosAmp = '0;
  logic [24:0] thrFastHi = 25'd1440000, thrSlowHi = 25'd1210000;
  logic [24:0] thrSlowLo = 25'd810000,  thrFastLo = 25'd640000;
  logic [24:0] targetSq  = 25'd1000000, targetWin = 25'd20000;
  logic [7:0]  initGain = 8'd128;
  logic [7:0]  gainCode;
  logic        regulating;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_agc #(.SAMPLE_W(12), .GAIN_W(8), .CLK_MHZ(125), .DIAG_NS(40),
             .FAST_NS(120), .SLOW_US(1)) i_quad_agc (
    .clk(clk), .rst(rst), .diagPhase(diagPhase), .sinAmp(sinAmp), .cosAmp(cosAmp),
    .thrFastHi(thrFastHi), .thrSlowHi(thrSlowHi), .thrSlowLo(thrSlowLo),
    .thrFastLo(thrFastLo), .targetSq(targetSq), .targetWin(targetWin),
    .initGain(initGain), .gainCode(gainCode), .regulating(regulating)
  );

  typedef struct packed {
    logic               diag;
    logic signed [11:0] s;
    logic signed [11:0] c;
    logic [7:0]         waitCyc;
    logic [7:0]         expGain;
    logic               expReg;
  } vec_t;

  // Period clocks: settling 5, fast 15, slow 125. Start gain 128.
  localparam vec_t VECS [10] = '{
    '{1'b0,  12'sd1300,     12'sd0,  8'd15,  8'd124, 1'b1},  // R3 far-high down 4
    '{1'b0,   12'sd500,   12'sd500,  8'd15,  8'd132, 1'b1},  // R3 far-low up 4
    '{1'b1,  12'sd1300,     12'sd0,   8'd5,  8'd120, 1'b1},  // R5 settle far-high 8
    '{1'b1,  -12'sd500,   12'sd500,   8'd5,  8'd136, 1'b1},  // R5 settle far-low 8
    '{1'b0,     12'sd0,  12'sd1150, 8'd125,  8'd127, 1'b1},  // R4 near-high 1
    '{1'b0,   12'sd850,     12'sd0, 8'd125,  8'd129, 1'b1},  // R4 near-low 1
    '{1'b1,     12'sd0, -12'sd1150,   8'd5,  8'd127, 1'b1},  // R5 settle near-high 1
    '{1'b1,     12'sd0,  -12'sd850,   8'd5,  8'd129, 1'b1},  // R5 settle near-low 1
    '{1'b0,  12'sd1000,   12'sd300, 8'd125,  8'd128, 1'b0},  // R8 quiet, idle
    '{1'b1,   12'sd600,  -12'sd800,   8'd5,  8'd128, 1'b0}   // R2 on target
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doReset(input logic [7:0] ig, input logic d,
                         input logic signed [11:0] s, input logic signed [11:0] c);
    @(posedge clk); #1;
    rst = 1'b1; initGain = ig; diagPhase = d; sinAmp = s; cosAmp = c;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    // R1 reset state
    doReset(8'd77, 1'b0, 12'sd1000, 12'sd300);
    chk("R1 gain after reset", gainCode, 77);
    chk("R1 regulating after reset", regulating, 0);

    // Table walk
    for (int i = 0; i < 10; i++) begin
      doReset(8'd128, VECS[i].diag, VECS[i].s, VECS[i].c);
      runEdges(int'(VECS[i].waitCyc) - 1);
      chk($sformatf("R2/R3/R4/R5 vec%0d before tick", i), gainCode, 128);
      runEdges(1);
      chk($sformatf("R2/R3/R4/R5 vec%0d gain", i), gainCode, VECS[i].expGain);
      chk($sformatf("R7 vec%0d regulating", i), regulating, VECS[i].expReg);
    end

    // R2 boundaries: exactly on the quiet-band edges is quiet
    doReset(8'd128, 1'b0, 12'sd1100, 12'sd0);
    runEdges(125);
    chk("R2 m==thrSlowHi quiet", gainCode, 128);
    doReset(8'd128, 1'b0, 12'sd900, 12'sd0);
    runEdges(125);
    chk("R2 m==thrSlowLo quiet", gainCode, 128);
    // exactly on fast-high is near-high: no fast step, one slow step
    doReset(8'd128, 1'b0, 12'sd1200, 12'sd0);
    runEdges(15);
    chk("R2 m==thrFastHi not fast", gainCode, 128);
    runEdges(110);
    chk("R2 m==thrFastHi slow step", gainCode, 127);

    // R6 saturation
    doReset(8'd254, 1'b1, 12'sd500, 12'sd500);
    runEdges(5);
    chk("R6 clamp at max", gainCode, 255);
    runEdges(5);
    chk("R6 hold at max", gainCode, 255);
    doReset(8'd3, 1'b0, 12'sd1300, 12'sd0);
    runEdges(15);
    chk("R6 clamp at zero", gainCode, 0);

    // R7 / R8 hysteresis sequence
    doReset(8'd128, 1'b0, 12'sd0, 12'sd1150);
    runEdges(125);
    chk("R7 near-high step", gainCode, 127);
    chk("R7 regulating set", regulating, 1);
    sinAmp = 12'sd1000; cosAmp = 12'sd300;
    runEdges(125);
    chk("R7 continues in quiet band", gainCode, 126);
    chk("R7 still regulating", regulating, 1);
    sinAmp = 12'sd600; cosAmp = 12'sd800;
    runEdges(1);
    chk("R7 clears on target", regulating, 0);
    runEdges(124);
    chk("R7 no step on target", gainCode, 126);
    sinAmp = 12'sd1000; cosAmp = 12'sd300;
    runEdges(125);
    chk("R8 quiet band holds", gainCode, 126);
    chk("R8 not regulating", regulating, 0);

    // R9 timer restart on phase change
    doReset(8'd128, 1'b0, 12'sd1300, 12'sd0);
    runEdges(10);
    diagPhase = 1'b1;
    runEdges(5);
    chk("R9 no step before new period", gainCode, 128);
    runEdges(1);
    chk("R9 step one period after change", gainCode, 120);

    done = 1'b1;
    finishRun();
  end

endmodule